// File: doc/BRIEF.md
# Handshaked Synchronous Serial Transmitter

This block sends single bytes over a three-wire synchronous link: a shift clock, a data line and an active-low acknowledge line from the receiver. The host writes a byte to the transmit register. The block then pulls the shift clock low, puts the most significant bit on the data line, and clocks out eight bits. The receiver samples each bit on the rising edge of the shift clock. The half-period of the shift clock is set by an 8-bit divider. After the last bit the clock rests high, and the block stays busy until the receiver returns a falling edge on the acknowledge line. A new byte therefore cannot overrun a receiver that has not yet taken the previous one.

A falling edge on the acknowledge line sets a sticky flag, which the host clears by writing one to it. The flag can raise an interrupt only when the interrupt enable is set. The ready output means "transmit register empty", so it is already high after reset, before any byte has been sent. A data write that arrives while the block is not ready is dropped and sets a sticky error flag.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset, ready is 1, link_clk is 1, and ack_flag, err_flag and irq are all 0.
- R2: A write to address 0 (data, bits 7:0) while ready is 1 is accepted. In the next cycle link_clk is 0, link_dat carries bit 7, and ready is 0.
- R3: The eight bits go out most significant first. link_dat changes only in the same cycle in which link_clk falls, so each bit is stable at the rising edge of link_clk.
- R4: Each low phase and each high phase of link_clk lasts n+2 system clocks. n is bits 7:0 of the last write to address 1 (divider) made before the byte starts. Bits 15:8 of that write are ignored. This gives a rate of clk/4 at n=0 and clk/514 at n=255.
- R5: After the eighth high phase, link_clk stays 1 and link_dat keeps the last bit. ready stays 0 until an acknowledge edge is accepted.
- R6: A falling edge on ack_n passes through a two-flop synchronizer, whatever the width of the low pulse (one clock or more). ack_flag rises three clock edges after the first edge that samples ack_n low. The same edge, when it arrives after the last bit has gone out, sets ready back to 1.
- R7: ack_flag is sticky. Writing address 3 with bit 0 set clears it. If a new edge arrives in the same cycle as the clear, the edge wins.
- R8: irq is 1 exactly when ack_flag is 1 and the enable (address 2, bit 0) is 1. ack_flag is set the same way whatever the enable holds.
- R9: A write to address 0 while ready is 0 is ignored and the byte in flight is unchanged. err_flag becomes 1 in the next cycle and stays 1 until address 3 is written with bit 1 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Register select: 0 data, 1 divider, 2 control, 3 flag clear |
| wr_data | input | 16 | Host write data |
| ack_n | input | 1 | Acknowledge from the receiver, active low, asynchronous |
| link_clk | output | 1 | Shift clock to the receiver, idles high |
| link_dat | output | 1 | Serial data to the receiver |
| ready | output | 1 | Transmit register empty |
| ack_flag | output | 1 | Sticky acknowledge-edge flag |
| err_flag | output | 1 | Sticky flag for a rejected data write |
| irq | output | 1 | Interrupt request |

## Verification
A data write that is accepted shows up one cycle later: the clock is low, the MSB is on the data line and ready is low. Each following clock level lasts exactly n+2 cycles, and ready stays low from the end of the 16(n+2)-cycle byte until an acknowledge edge arrives. An acknowledge edge is seen three edges after ack_n is first sampled low, so the bench checks that ack_flag is still 0 two cycles after the drop and is 1 one cycle after that. Flag clears and the error flag are checked one cycle after their write. The bench drives its inputs on falling clock edges and samples on falling edges, one sample per system clock. It measures the length of every clock level by counting those samples and captures each data bit in the sample where link_clk first reads high.

// File: rtl/sstx_pkg.sv
package sstx_pkg;
   localparam logic [1:0] REG_DATA = 2'd0;
   localparam logic [1:0] REG_DIV  = 2'd1;
   localparam logic [1:0] REG_CTRL = 2'd2;
   localparam logic [1:0] REG_CLR  = 2'd3;

   localparam int CTRL_IRQ_EN_BIT = 0;
   localparam int CLR_ACK_BIT     = 0;
   localparam int CLR_ERR_BIT     = 1;
endpackage

// File: rtl/sstx_ack_sync.sv
module sstx_ack_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_n,
   output logic ack_fall
);
   logic [STAGES-1:0] stage_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sstx_ack_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= 1'b1;
               else        stage_q[0] <= ack_n;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= 1'b1;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b1;
      else        last_q <= stage_q[STAGES-1];
   end

   assign ack_fall = last_q & ~stage_q[STAGES-1];
endmodule

// File: rtl/sstx_shift_engine.sv
module sstx_shift_engine #(
   parameter int DATA_W = 8,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] din,
   input  logic [DIV_W-1:0]  div,
   output logic              active,
   output logic              done,
   output logic              line_clk,
   output logic              line_dat
);
   localparam int CNT_W = DIV_W + 1;
   localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

   logic              busy_q;
   logic [DIV_W-1:0]  div_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] sh_q;
   logic [BIT_W-1:0]  bit_q;
   logic              clk_q;
   logic              dat_q;
   logic              phase_end;

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("sstx_shift_engine: DATA_W must be at least 2");
      end
   endgenerate

   assign phase_end = busy_q && (cnt_q == '0);
   assign done      = phase_end && clk_q && (bit_q == LAST_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         div_q  <= '0;
         cnt_q  <= '0;
         sh_q   <= '0;
         bit_q  <= '0;
         clk_q  <= 1'b1;
         dat_q  <= 1'b0;
      end else if (start) begin
         busy_q <= 1'b1;
         div_q  <= div;
         cnt_q  <= {1'b0, div} + CNT_W'(1);
         clk_q  <= 1'b0;
         dat_q  <= din[DATA_W-1];
         sh_q   <= {din[DATA_W-2:0], 1'b0};
         bit_q  <= '0;
      end else if (busy_q) begin
         if (!phase_end) begin
            cnt_q <= cnt_q - CNT_W'(1);
         end else begin
            cnt_q <= {1'b0, div_q} + CNT_W'(1);
            if (!clk_q) begin
               clk_q <= 1'b1;
            end else if (bit_q == LAST_BIT) begin
               busy_q <= 1'b0;
            end else begin
               clk_q <= 1'b0;
               dat_q <= sh_q[DATA_W-1];
               sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
               bit_q <= bit_q + BIT_W'(1);
            end
         end
      end
   end

   assign active   = busy_q;
   assign line_clk = clk_q;
   assign line_dat = dat_q;
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
   import sstx_pkg::*;
#(
   parameter int               HOST_W      = 16,
   parameter int               DATA_W      = 8,
   parameter int               DIV_W       = 8,
   parameter int               SYNC_STAGES = 2,
   parameter logic [DIV_W-1:0] DIV_RST     = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [HOST_W-1:0] wr_data,
   input  logic              ack_n,
   output logic              link_clk,
   output logic              link_dat,
   output logic              ready,
   output logic              ack_flag,
   output logic              err_flag,
   output logic              irq
);
   generate
      if (HOST_W <= DIV_W || HOST_W < DATA_W || HOST_W < 2) begin : g_bad_host
         $error("sync_ser_tx: HOST_W must exceed DIV_W and cover DATA_W");
      end
   endgenerate

   logic [DIV_W-1:0] div_r;
   logic             irq_en_r;
   logic             ack_flag_r;
   logic             err_r;
   logic             hold_r;
   logic             eng_active;
   logic             eng_done;
   logic             ack_fall;
   logic             data_wr;
   logic             start;
   logic             reject;
   logic             clr_wr;
   logic             unused_hi;

   assign unused_hi = &{1'b0, wr_data[HOST_W-1:DIV_W]};

   assign ready   = !eng_active && !hold_r;
   assign data_wr = wr_en && (wr_addr == REG_DATA);
   assign start   = data_wr && ready;
   assign reject  = data_wr && !ready;
   assign clr_wr  = wr_en && (wr_addr == REG_CLR);

   sstx_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .ack_n    (ack_n),
      .ack_fall (ack_fall)
   );

   sstx_shift_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .din      (wr_data[DATA_W-1:0]),
      .div      (div_r),
      .active   (eng_active),
      .done     (eng_done),
      .line_clk (link_clk),
      .line_dat (link_dat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_r    <= DIV_RST;
         irq_en_r <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == REG_DIV)  div_r    <= wr_data[DIV_W-1:0];
         if (wr_addr == REG_CTRL) irq_en_r <= wr_data[CTRL_IRQ_EN_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_flag_r <= 1'b0;
         err_r      <= 1'b0;
         hold_r     <= 1'b0;
      end else begin
         if (ack_fall)                             ack_flag_r <= 1'b1;
         else if (clr_wr && wr_data[CLR_ACK_BIT])  ack_flag_r <= 1'b0;

         if (reject)                               err_r <= 1'b1;
         else if (clr_wr && wr_data[CLR_ERR_BIT])  err_r <= 1'b0;

         if (eng_done)                             hold_r <= 1'b1;
         else if (ack_fall)                        hold_r <= 1'b0;
      end
   end

   assign ack_flag = ack_flag_r;
   assign err_flag = err_r;
   assign irq      = ack_flag_r && irq_en_r;
endmodule

// File: rtl/sstx_chk.sv
module sstx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [1:0] wr_addr,
   input logic       clr_ack_bit,
   input logic       clr_err_bit,
   input logic       link_clk,
   input logic       link_dat,
   input logic       ready,
   input logic       ack_flag,
   input logic       err_flag,
   input logic       irq,
   input logic       irq_en_r
);
   logic data_wr;
   assign data_wr = wr_en && (wr_addr == 2'd0);

   AST_START_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && ready) |=> (!link_clk && !ready)); // R2

   AST_DAT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(link_dat) |-> $fell(link_clk)); // R3

   AST_READY_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> link_clk); // R5

   AST_ACK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_flag && !(wr_en && wr_addr == 2'd3 && clr_ack_bit)) |=> ack_flag); // R7

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en_r |-> !irq); // R8

   AST_REJECT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !ready) |=> (err_flag && !ready)); // R9

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !(wr_en && wr_addr == 2'd3 && clr_err_bit)) |=> err_flag); // R9
endmodule

bind sync_ser_tx sstx_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .clr_ack_bit (wr_data[0]),
   .clr_err_bit (wr_data[1]),
   .link_clk    (link_clk),
   .link_dat    (link_dat),
   .ready       (ready),
   .ack_flag    (ack_flag),
   .err_flag    (err_flag),
   .irq         (irq),
   .irq_en_r    (irq_en_r)
);

// File: tb/sim_sync_ser_tx.sv
module sim_sync_ser_tx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [15:0] wr_data = 16'd0;
   logic        ack_n = 1'b1;
   logic        link_clk, link_dat, ready, ack_flag, err_flag, irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done_run = 1'b0;

   always #5 clk = ~clk;

   sync_ser_tx u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .ack_n(ack_n), .link_clk(link_clk),
      .link_dat(link_dat), .ready(ready), .ack_flag(ack_flag),
      .err_flag(err_flag), .irq(irq)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic host_wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] d, input int n, input int intrude);
      int half;
      int run;
      int bad_runs;
      logic prev;
      logic [7:0] got;
      half = n + 2;
      run = 0; bad_runs = 0; prev = 1'b1; got = 8'h00;
      host_wr(2'd0, {8'h00, d});
      check(link_clk == 1'b0, "R2 clk low after start", int'(link_clk), 0);
      check(link_dat == d[7], "R2 msb driven at start", int'(link_dat), int'(d[7]));
      check(ready == 1'b0, "R2 ready low after start", int'(ready), 0);
      for (int i = 0; i < 16 * half; i++) begin
         if (i > 0) @(negedge clk);
         wr_en = 1'b0;
         if (link_clk != prev) begin
            if (i > 0 && run != half) bad_runs++;
            if (link_clk) got = {got[6:0], link_dat};
            run = 1;
         end else begin
            run++;
         end
         prev = link_clk;
         if (i == intrude) begin
            wr_en = 1'b1; wr_addr = 2'd0; wr_data = {8'h00, ~d};
         end
      end
      check(bad_runs == 0 && run == half, "R4 half period length", run, half);
      check(got == d, "R3 bits msb first", int'(got), int'(d));
      @(negedge clk);
      wr_en = 1'b0;
      check(link_clk == 1'b1, "R5 clock rests high", int'(link_clk), 1);
      check(ready == 1'b0, "R5 busy until ack", int'(ready), 0);
   endtask

   task automatic pulse_ack(input int width, input bit expect_release);
      bit pre;
      pre = ack_flag;
      ack_n = 1'b0;
      for (int k = 1; k <= 3; k++) begin
         @(negedge clk);
         if (k == width) ack_n = 1'b1;
         if (k == 2 && !pre) check(ack_flag == 1'b0, "R6 flag not early", int'(ack_flag), 0);
      end
      check(ack_flag == 1'b1, "R6 flag set on third edge", int'(ack_flag), 1);
      if (expect_release) check(ready == 1'b1, "R6 ready after ack", int'(ready), 1);
      for (int k = 4; k <= width; k++) @(negedge clk);
      ack_n = 1'b1;
   endtask

   task automatic t_reset;
      check(ready == 1'b1, "R1 ready after reset", int'(ready), 1);
      check(link_clk == 1'b1, "R1 clock idle high", int'(link_clk), 1);
      check(ack_flag == 1'b0 && err_flag == 1'b0, "R1 flags clear", int'({ack_flag, err_flag}), 0);
      check(irq == 1'b0, "R1 irq low", int'(irq), 0);
   endtask

   task automatic t_fast_byte;
      host_wr(2'd1, 16'h0000);
      send_byte(8'hA5, 0, -1);
      repeat (10) @(negedge clk);
      check(ready == 1'b0 && link_clk == 1'b1, "R5 waits for ack", int'({ready, link_clk}), 1);
      check(link_dat == 1'b1, "R5 data holds lsb", int'(link_dat), 1);
   endtask

   task automatic t_write_in_hold;
      host_wr(2'd0, 16'h0055);
      check(err_flag == 1'b1, "R9 error on write in hold", int'(err_flag), 1);
      check(ready == 1'b0 && link_clk == 1'b1, "R9 hold write ignored", int'({ready, link_clk}), 1);
      repeat (3) @(negedge clk);
      check(err_flag == 1'b1, "R9 error sticky", int'(err_flag), 1);
      host_wr(2'd3, 16'h0002);
      check(err_flag == 1'b0, "R9 error cleared", int'(err_flag), 0);
   endtask

   task automatic t_ack_irq;
      pulse_ack(1, 1'b1);
      check(irq == 1'b0, "R8 irq masked", int'(irq), 0);
      repeat (5) @(negedge clk);
      check(ack_flag == 1'b1, "R7 flag sticky", int'(ack_flag), 1);
      host_wr(2'd2, 16'h0001);
      check(irq == 1'b1, "R8 irq when enabled", int'(irq), 1);
      host_wr(2'd3, 16'h0001);
      check(ack_flag == 1'b0, "R7 flag cleared", int'(ack_flag), 0);
      check(irq == 1'b0, "R8 irq drops with flag", int'(irq), 0);
      host_wr(2'd2, 16'h0000);
   endtask

   task automatic t_upper_ignored_intrude;
      host_wr(2'd1, 16'hFF03);
      send_byte(8'h3C, 3, 7);
      check(err_flag == 1'b1, "R9 error on write in shift", int'(err_flag), 1);
      pulse_ack(12, 1'b1);
      host_wr(2'd3, 16'h0003);
      check(ack_flag == 1'b0 && err_flag == 1'b0, "R7 both flags cleared", int'({ack_flag, err_flag}), 0);
   endtask

   task automatic t_slowest;
      host_wr(2'd1, 16'h00FF);
      send_byte(8'h81, 255, -1);
      pulse_ack(2, 1'b1);
      host_wr(2'd3, 16'h0001);
      pulse_ack(4, 1'b1);
      check(link_clk == 1'b1, "R6 idle ack keeps clock high", int'(link_clk), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fast_byte();
      t_write_in_hold();
      t_ack_irq();
      t_upper_ignored_intrude();
      t_slowest();
      done_run = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_run) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule